// File: doc/BRIEF.md
# Power domain and module clock sequencer

This block steps one power domain and one module through their power, reset and clock states under software control. Software uses a simple synchronous register bus to write a requested module state, a local-reset request and a domain power-on request. None of these takes effect when written. A go command starts a timed transition of fixed length, and a busy flag stays set while it runs. On the cycle the busy flag clears, the committed domain state and module state change together.

The module clock-enable, module local-reset and domain power outputs come only from the committed state. They stand in for the clock gate, the reset tree and the power switch of a larger chip. Read data is combinational from the address, so it reflects the state in the same cycle. Unused address space reads as zero and ignores writes.

The sequencer has three states:

- `SEQ_IDLE` waits for a go command. When one arrives, the transition **start** takes a snapshot of the requests and moves to `SEQ_RUN`.
- `SEQ_RUN` counts the transition. When the count reaches its last value, the transition **finish** moves to `SEQ_COMMIT`.
- `SEQ_COMMIT` lasts one cycle. Its transition **commit** loads the committed state and returns to `SEQ_IDLE`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset:
  - the domain status reads 0 and `dom_pwr_on` is low;
  - the module state reads 0;
  - `mod_clk_en` is low and `mod_lrst` is high;
  - the busy flag is clear;
  - the module control register reads 0.
- R2: The module control register (offset 0xA00) reads back the fields written to it, and all other bits read 0. Its fields are:
  - the next state in bits 5:0;
  - the active-low local-reset request in bit 8;
  - the force flag in bit 31.

  The domain control register (offset 0x300) reads back only bit 0, the power-on request.
- R3: When the sequencer is idle, writing 1 to bit 0 of the go register (offset 0x120) sets bit 0 of the busy register (offset 0x128). The busy bit stays set for exactly TRANS_CYCLES cycles, counted from the write edge. A go write with bit 0 clear starts nothing.
- R4: While busy, the module status (offset 0x800) and the domain status (offset 0x200) keep their old values. On the edge where busy clears, module status bits 5:0 take the next state captured at the go command. The one exception is the case in R6.
- R5: If domain control bit 0 was set at the go command, domain status bits 4:0 read 1 and `dom_pwr_on` goes high at completion. If the bit was clear, the domain state is kept.
- R6: A request for state 3 (enable) commits as state 2 (disable) when the domain is still off after the transition. In that case the clock stays off.
- R7: `mod_clk_en` and module status bit 12 are high exactly when the committed module state is 3.
- R8: `mod_lrst` is high when any of the following holds:
  - the committed state is 0;
  - the committed state is 1;
  - the local-reset request bit captured at the go command was 0.
- R9: A go write while busy does not restart or extend the transition. Writes to module control or domain control while busy are stored, but they take effect only at the next go command.
- R10: The go register reads 0. Unmapped addresses read 0, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mod_clk_en | output | 1 | Module clock enable |
| mod_lrst | output | 1 | Module local reset, active high |
| dom_pwr_on | output | 1 | Domain power switch request |

## Verification
A wrong sequencer state shows at the ports in one of two ways:

- The busy bit clears at a cycle other than exactly TRANS_CYCLES edges after the go write.
- The busy bit stays set indefinitely.

Both are visible within one transition length. A wrong snapshot or commit shows up on the first read of module or domain status after busy clears. It also shows up at once on `mod_clk_en`, `mod_lrst` and `dom_pwr_on`, because these follow the committed state with no delay. A request that leaks into the committed state too early shows as a status change while busy is still set.

// File: rtl/pscx_pkg.sv
package pscx_pkg;

    localparam int unsigned STATE_W = 6;
    localparam int unsigned DOM_W   = 5;

    localparam logic [11:0] OFF_GO   = 12'h120;
    localparam logic [11:0] OFF_BUSY = 12'h128;
    localparam logic [11:0] OFF_DST  = 12'h200;
    localparam logic [11:0] OFF_DCTL = 12'h300;
    localparam logic [11:0] OFF_MST  = 12'h800;
    localparam logic [11:0] OFF_MCTL = 12'hA00;

    localparam int unsigned MCTL_LRSTN_BIT = 8;
    localparam int unsigned MCTL_FRC_BIT   = 31;
    localparam int unsigned MST_CLK_BIT    = 12;

    localparam logic [STATE_W-1:0] MS_SWRST_OFF = 6'd0;
    localparam logic [STATE_W-1:0] MS_SYNC_RST  = 6'd1;
    localparam logic [STATE_W-1:0] MS_DISABLE   = 6'd2;
    localparam logic [STATE_W-1:0] MS_ENABLE    = 6'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_COMMIT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic               frc;
        logic               lrst_n;
        logic [STATE_W-1:0] next;
        logic               dom_up;
    } req_t;

endpackage

// File: rtl/pscx_regs.sv
module pscx_regs
    import pscx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DOM_ID = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               busy,
    input  logic [STATE_W-1:0] cmt_state,
    input  logic               dom_on,
    input  logic               clk_run,
    output req_t               req,
    output logic               go_pulse,
    output logic [DATA_W-1:0]  rdata
);

    logic hit_mctl, hit_dctl, hit_go;

    assign hit_mctl = we && (addr == ADDR_W'(OFF_MCTL));
    assign hit_dctl = we && (addr == ADDR_W'(OFF_DCTL));
    assign hit_go   = we && (addr == ADDR_W'(OFF_GO));
    assign go_pulse = hit_go && wdata[DOM_ID];

    // Control registers accept writes at any time; the sequencer snapshots them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            if (hit_mctl) begin
                req.frc    <= wdata[MCTL_FRC_BIT];
                req.lrst_n <= wdata[MCTL_LRSTN_BIT];
                req.next   <= wdata[STATE_W-1:0];
            end
            if (hit_dctl) begin
                req.dom_up <= wdata[0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_BUSY): rdata[DOM_ID] = busy;
            ADDR_W'(OFF_DST):  rdata[DOM_W-1:0] = DOM_W'(dom_on);
            ADDR_W'(OFF_DCTL): rdata[0] = req.dom_up;
            ADDR_W'(OFF_MST): begin
                rdata[STATE_W-1:0]  = cmt_state;
                rdata[MST_CLK_BIT]  = clk_run;
            end
            ADDR_W'(OFF_MCTL): begin
                rdata[STATE_W-1:0]     = req.next;
                rdata[MCTL_LRSTN_BIT]  = req.lrst_n;
                rdata[MCTL_FRC_BIT]    = req.frc;
            end
            default: rdata = '0;
        endcase
    end

    // R2: a module-control write is visible on the following cycle
    assert_mctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mctl |=> (req.next == $past(wdata[STATE_W-1:0])));

endmodule

// File: rtl/pscx_seq.sv
module pscx_seq
    import pscx_pkg::*;
#(
    parameter int unsigned TRANS_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_pulse,
    input  req_t               req,
    output logic               busy,
    output logic [STATE_W-1:0] cmt_state,
    output logic               cmt_lrst_n,
    output logic               dom_on
);

    localparam int unsigned CNT_W = (TRANS_CYCLES > 2) ? $clog2(TRANS_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRANS_CYCLES - 2);

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    req_t             snap_q;
    logic             dom_after;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   if (go_pulse) st_d = SEQ_RUN;
            SEQ_RUN:    if (cnt_q == CNT_LAST) st_d = SEQ_COMMIT;
            SEQ_COMMIT: st_d = SEQ_IDLE;
            default:    st_d = SEQ_IDLE;
        endcase
    end

    assign busy      = (st_q != SEQ_IDLE);
    assign dom_after = snap_q.dom_up | dom_on;

    // outputs: counter, snapshot and committed state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            snap_q     <= '0;
            cmt_state  <= MS_SWRST_OFF;
            cmt_lrst_n <= 1'b0;
            dom_on     <= 1'b0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (go_pulse) snap_q <= req;
                end
                SEQ_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                SEQ_COMMIT: begin
                    dom_on     <= dom_after;
                    cmt_lrst_n <= snap_q.lrst_n;
                    if (snap_q.next == MS_ENABLE && !dom_after)
                        cmt_state <= MS_DISABLE;
                    else
                        cmt_state <= snap_q.next;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // R3: an idle go starts the transition
    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && !busy) |=> busy);

    // R4: committed state holds until the commit cycle
    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_RUN) |=> ($stable(cmt_state) && $stable(dom_on) && busy));

    // R9: the snapshot is frozen while a transition runs
    assert_snap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(snap_q));

    // R4: with power present the committed state equals the captured request
    assert_commit_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_COMMIT && dom_after) |=> (cmt_state == $past(snap_q.next)));

endmodule

// File: rtl/pscx_outs.sv
module pscx_outs
    import pscx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] cmt_state,
    input  logic               cmt_lrst_n,
    input  logic               dom_on,
    output logic               clk_run,
    output logic               lrst
);

    always_comb begin
        clk_run = (cmt_state == MS_ENABLE);
        lrst    = (cmt_state == MS_SWRST_OFF) || (cmt_state == MS_SYNC_RST) || !cmt_lrst_n;
    end

    // R6: the module clock never runs in an unpowered domain
    assert_clk_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_run |-> dom_on);

    // R8: a running clock comes with a released local reset unless software holds it
    assert_clk_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && cmt_lrst_n) |-> !lrst);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pscx_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned DOM_ID       = 0,
    parameter int unsigned TRANS_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mod_clk_en,
    output logic              mod_lrst,
    output logic              dom_pwr_on
);

    req_t               req;
    logic               go_pulse;
    logic               busy;
    logic [STATE_W-1:0] cmt_state;
    logic               cmt_lrst_n;
    logic               dom_on;
    logic               clk_run;
    logic               lrst;

    pscx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DOM_ID(DOM_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .busy(busy), .cmt_state(cmt_state), .dom_on(dom_on), .clk_run(clk_run),
        .req(req), .go_pulse(go_pulse), .rdata(bus_rdata)
    );

    pscx_seq #(.TRANS_CYCLES(TRANS_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_pulse(go_pulse), .req(req),
        .busy(busy), .cmt_state(cmt_state), .cmt_lrst_n(cmt_lrst_n), .dom_on(dom_on)
    );

    pscx_outs u_outs (
        .clk(clk), .rst_n(rst_n), .cmt_state(cmt_state), .cmt_lrst_n(cmt_lrst_n),
        .dom_on(dom_on), .clk_run(clk_run), .lrst(lrst)
    );

    assign mod_clk_en = clk_run;
    assign mod_lrst   = lrst;
    assign dom_pwr_on = dom_on;

    // R5: domain power, once committed on, stays on
    assert_dom_stays_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dom_pwr_on |=> dom_pwr_on);

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;

    localparam int TC = 16;
    localparam logic [11:0] A_GO = 12'h120, A_BUSY = 12'h128, A_DST = 12'h200,
                            A_DCTL = 12'h300, A_MST = 12'h800, A_MCTL = 12'hA00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mod_clk_en, mod_lrst, dom_pwr_on;

    int n_chk = 0;
    int n_fail = 0;

    pwr_seq_ctrl #(.TRANS_CYCLES(TC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_clk_en(mod_clk_en),
        .mod_lrst(mod_lrst), .dom_pwr_on(dom_pwr_on)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // go, then check busy timing and that status holds until the last edge
    task automatic run_go(input logic [31:0] old_mst);
        logic [31:0] v;
        wr(A_GO, 32'h1);
        edges(TC - 1);
        rd(A_BUSY, v); chk("R3 busy set at last busy cycle", v, 32'h1);
        rd(A_MST, v);  chk("R4 status held while busy", v, old_mst);
        edges(1);
        rd(A_BUSY, v); chk("R3 busy clear after TRANS_CYCLES", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v, exp_mst;
        logic exp_dom;
        exp_dom = 1'b0;
        exp_mst = 32'h0;
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd(A_MST, v);  chk("R1 module status", v, 32'h0);
        rd(A_DST, v);  chk("R1 domain status", v, 32'h0);
        rd(A_BUSY, v); chk("R1 busy", v, 32'h0);
        rd(A_MCTL, v); chk("R1 module control", v, 32'h0);
        chk("R1 outputs clk/lrst/pwr", {29'b0, mod_clk_en, mod_lrst, dom_pwr_on}, 32'h2);

        // R2 readback
        wr(A_MCTL, 32'hFFFF_FFFF);
        rd(A_MCTL, v); chk("R2 module control fields", v, 32'h8000_013F);
        wr(A_DCTL, 32'hFFFF_FFFF);
        rd(A_DCTL, v); chk("R2 domain control bit0", v, 32'h1);
        wr(A_DCTL, 32'h0);
        wr(A_MCTL, 32'h0);

        // R10 go reads zero, unmapped space inert
        rd(A_GO, v); chk("R10 go register reads 0", v, 32'h0);
        wr(12'h124, 32'hFFFF_FFFF);
        rd(12'h124, v); chk("R10 unmapped read", v, 32'h0);
        rd(A_MCTL, v); chk("R10 unmapped write left module control", v, 32'h0);
        rd(A_DCTL, v); chk("R10 unmapped write left domain control", v, 32'h0);
        rd(A_BUSY, v); chk("R10 unmapped write started nothing", v, 32'h0);

        // R3 go with bit 0 clear does nothing
        wr(A_GO, 32'h2);
        rd(A_BUSY, v); chk("R3 go without own bit", v, 32'h0);

        // Sweep: domain request, next state, local-reset bit
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 6; s++) begin
                for (int lb = 0; lb < 2; lb++) begin
                    logic [5:0] est;
                    wr(A_MCTL, (32'(lb) << 8) | 32'(s));
                    wr(A_DCTL, 32'(d));
                    run_go(exp_mst);
                    if (d == 1) exp_dom = 1'b1;
                    est = (s == 3 && !exp_dom) ? 6'd2 : 6'(s);
                    exp_mst = {19'b0, (est == 6'd3), 6'b0, est};
                    rd(A_MST, v); chk("R4 R6 R7 module status", v, exp_mst);
                    rd(A_DST, v); chk("R5 domain status", v, {31'b0, exp_dom});
                    chk("R5 dom_pwr_on", {31'b0, dom_pwr_on}, {31'b0, exp_dom});
                    chk("R7 mod_clk_en", {31'b0, mod_clk_en}, {31'b0, (est == 6'd3)});
                    chk("R8 mod_lrst", {31'b0, mod_lrst},
                        {31'b0, (est < 6'd2) || (lb == 0)});
                end
            end
        end

        // R9 control writes during busy wait for the next go
        wr(A_MCTL, 32'h0000_0103);
        wr(A_GO, 32'h1);
        edges(3);
        wr(A_MCTL, 32'h0000_0001);
        edges(TC - 5);
        rd(A_BUSY, v); chk("R9 busy before end", v, 32'h1);
        edges(1);
        rd(A_MST, v); chk("R9 late write not applied", v, 32'h0000_1003);
        chk("R9 clock on", {31'b0, mod_clk_en}, 32'h1);
        chk("R8 reset released in enable", {31'b0, mod_lrst}, 32'h0);
        exp_mst = 32'h0000_1003;
        run_go(exp_mst);
        rd(A_MST, v); chk("R9 stored write applied at next go", v, 32'h1);
        chk("R8 lrst in sync reset", {31'b0, mod_lrst}, 32'h1);
        chk("R7 clock off in sync reset", {31'b0, mod_clk_en}, 32'h0);

        // R9 go while busy does not extend
        wr(A_MCTL, 32'h0000_0103);
        wr(A_GO, 32'h1);
        edges(4);
        wr(A_GO, 32'h1);
        edges(TC - 6);
        rd(A_BUSY, v); chk("R9 still busy at last cycle", v, 32'h1);
        edges(1);
        rd(A_BUSY, v); chk("R9 second go ignored", v, 32'h0);
        rd(A_MST, v); chk("R9 committed after single run", v, 32'h0000_1003);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule